// File: doc/BRIEF.md
# Two-Register ALU Stage with Condition Flags

This block executes the register-to-register arithmetic and logic group of a 16-bit compressed instruction encoding. Each valid instruction word arrives with the values of its two operand registers. The block decodes a 4-bit operation field and the 3-bit source and destination register indices. It produces a 32-bit result, a write strobe with its register index, and an updated set of condition flags. The block holds the flag set itself, so carry-consuming operations use whatever carry the previous operation left behind.

An issued instruction completes in one clock. The result, write strobe and flags appear on the cycle after `inValid` is sampled high. There are sixteen operations: bitwise, shifts by a register amount, add and subtract with carry, negate, multiply, and three compare-style operations. The compare-style operations update flags only and do not write back.

Top module: `rr_alu_unit`

## Requirements
- R1: Operation is `instr[9:6]`, source index is `instr[5:3]` and destination index is `instr[2:0]`. `outValid` rises on the cycle after `inValid` is sampled high, and `wrIdx` carries the destination index.
- R2: Opcodes 0000 AND, 0001 XOR, 1100 OR, 1110 Rd AND NOT Rs, 1111 NOT Rs and 1101 multiply (low 32 bits of the product) write their result. Rd is `rdVal` and Rs is `rsVal`.
- R3: Opcodes 1000 (test: Rd AND Rs), 1010 (compare: Rd − Rs) and 1011 (compare-negative: Rd + Rs) update flags with `wrEn` low, and `result` still shows the computed value.
- R4: Opcode 0101 computes Rd + Rs + C, 0110 computes Rd − Rs − (1 − C), and 1001 computes 0 − Rs. For these and for compare/compare-negative, C is the adder carry-out (subtract with no borrow gives C=1) and V is signed overflow.
- R5: `nzcv[3]` (N) equals result bit 31 and `nzcv[2]` (Z) is set when result is zero, after every operation.
- R6: Shifts are 0010 left logical, 0011 right logical, 0100 right arithmetic and 0111 rotate right. The amount is `rsVal[7:0]`, and upper bits are ignored. For amounts 1..31, C (`nzcv[1]`) is the last bit shifted out.
- R7: A shift amount of zero returns Rd unchanged and leaves C unchanged.
- R8: For amounts of 32 or more, left/right logical shifts give 0. C is Rd bit 0 (left) or bit 31 (right) at exactly 32, and 0 above 32. Arithmetic shift fills with bit 31 and sets C to bit 31. Rotate uses the amount modulo 32, and a nonzero multiple of 32 returns Rd with C set to bit 31.
- R9: Bitwise, multiply and test operations leave C and V unchanged, and shifts leave V (`nzcv[0]`) unchanged.
- R10: While `inValid` is low, `outValid` and `wrEn` are low and the flags hold.
- R11: After reset, `outValid`, `wrEn` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| rdVal | input | 32 | Value of the destination/first operand register |
| rsVal | input | 32 | Value of the source register |
| outValid | output | 1 | Result of the previous issue is present |
| wrEn | output | 1 | Write result to register `wrIdx` |
| wrIdx | output | 3 | Destination register index |
| result | output | 32 | Computed value |
| nzcv | output | 4 | Flags: bit 3 N, bit 2 Z, bit 1 C, bit 0 V |

## Verification
The hardest states to reach are the shift corners where carry depends on the exact amount: zero, exactly 32, above 32, and rotate by a multiple of 32. Each of these must be checked against a carry value that the stimulus has deliberately set beforehand. The bench chains operations so that each corner starts from a known flag state. A compare first sets C and V to 1, and later shifts start from both carry polarities. This makes an unchanged carry distinguishable from a newly written one. Carry-in sensitivity is exercised the same way: add-with-carry runs after a carry of 1, and subtract-with-carry runs after a carry of 0.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;
  localparam int INSTR_W = 16;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_XOR = 4'b0001, OP_LSL = 4'b0010, OP_LSR = 4'b0011,
    OP_ASR = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_ROR = 4'b0111,
    OP_TST = 4'b1000, OP_NEG = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_ORR = 4'b1100, OP_MUL = 4'b1101, OP_BIC = 4'b1110, OP_MVN = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] { SH_LEFT, SH_RIGHT, SH_ARITH, SH_ROT } shift_e;
  typedef enum logic [2:0] { LG_AND, LG_XOR, LG_OR, LG_BIC, LG_NOT, LG_MUL } logic_e;
  typedef enum logic [1:0] { CIN_ZERO, CIN_ONE, CIN_FLAG } cin_e;

  typedef struct packed {
    logic   wrBack;
    logic   isShift;
    logic   isArith;
    logic   zeroA;
    logic   invB;
    cin_e   cinSel;
    shift_e shKind;
    logic_e lgSel;
  } alu_ctrl_t;
endpackage

// File: rtl/rr_alu_ctrl.sv
module rr_alu_ctrl
  import rr_alu_pkg::*;
(
  input  logic [3:0] opField,
  output alu_ctrl_t  strobes
);
  always_comb begin
    strobes = '{wrBack: 1'b1, isShift: 1'b0, isArith: 1'b0, zeroA: 1'b0,
                invB: 1'b0, cinSel: CIN_ZERO, shKind: SH_LEFT, lgSel: LG_AND};
    unique case (alu_op_e'(opField))
      OP_AND: strobes.lgSel = LG_AND;
      OP_XOR: strobes.lgSel = LG_XOR;
      OP_ORR: strobes.lgSel = LG_OR;
      OP_BIC: strobes.lgSel = LG_BIC;
      OP_MVN: strobes.lgSel = LG_NOT;
      OP_MUL: strobes.lgSel = LG_MUL;
      OP_TST: begin strobes.lgSel = LG_AND; strobes.wrBack = 1'b0; end
      OP_LSL: begin strobes.isShift = 1'b1; strobes.shKind = SH_LEFT;  end
      OP_LSR: begin strobes.isShift = 1'b1; strobes.shKind = SH_RIGHT; end
      OP_ASR: begin strobes.isShift = 1'b1; strobes.shKind = SH_ARITH; end
      OP_ROR: begin strobes.isShift = 1'b1; strobes.shKind = SH_ROT;   end
      OP_ADC: begin strobes.isArith = 1'b1; strobes.cinSel = CIN_FLAG; end
      OP_SBC: begin
        strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_FLAG;
      end
      OP_CMP: begin
        strobes.isArith = 1'b1; strobes.invB = 1'b1; strobes.cinSel = CIN_ONE;
        strobes.wrBack = 1'b0;
      end
      OP_CMN: begin strobes.isArith = 1'b1; strobes.wrBack = 1'b0; end
      OP_NEG: begin
        strobes.isArith = 1'b1; strobes.zeroA = 1'b1; strobes.invB = 1'b1;
        strobes.cinSel = CIN_ONE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_alu_dpath.sv
module rr_alu_dpath
  import rr_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  alu_ctrl_t    strobes,
  input  logic [2:0]   dstIdx,
  input  logic [W-1:0] rdVal,
  input  logic [W-1:0] rsVal,
  output logic         outValid,
  output logic         wrEn,
  output logic [2:0]   wrIdx,
  output logic [W-1:0] result,
  output logic [3:0]   nzcv
);
  localparam int SH_W = $clog2(W);
  localparam logic [7:0] AMT_FULL = 8'(W);

  logic         curC;
  logic [W-1:0] addA, addB, addSum;
  logic         addCin, addCout, addOvf;
  logic [W-1:0] lgRes;
  logic [2*W-1:0] mulFull;
  logic [7:0]   amt;
  logic [SH_W-1:0] amtLow;
  logic [W-1:0] shRes;
  logic         shC, shCValid;
  logic [W:0]   lslExt, lsrExt;
  logic signed [W:0] asrExt;
  logic [2*W-1:0] rorExt;
  logic [W-1:0] nextRes;
  logic         nextC, nextV;

  assign curC = nzcv[1];

  // Adder shared by carry-add, borrow-subtract, compares and negate
  always_comb begin
    addA   = strobes.zeroA ? '0 : rdVal;
    addB   = strobes.invB ? ~rsVal : rsVal;
    unique case (strobes.cinSel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = curC;
      default:  addCin = 1'b0;
    endcase
    {addCout, addSum} = {1'b0, addA} + {1'b0, addB} + {{W{1'b0}}, addCin};
    addOvf = (addA[W-1] == addB[W-1]) && (addSum[W-1] != addA[W-1]);
  end

  // Bitwise and multiply
  assign mulFull = rdVal * rsVal;
  always_comb begin
    unique case (strobes.lgSel)
      LG_XOR:  lgRes = rdVal ^ rsVal;
      LG_OR:   lgRes = rdVal | rsVal;
      LG_BIC:  lgRes = rdVal & ~rsVal;
      LG_NOT:  lgRes = ~rsVal;
      LG_MUL:  lgRes = mulFull[W-1:0];
      default: lgRes = rdVal & rsVal;
    endcase
  end

  // Register-amount shifter
  assign amt    = rsVal[7:0];
  assign amtLow = amt[SH_W-1:0];
  assign lslExt = {1'b0, rdVal} << amtLow;
  assign lsrExt = {rdVal, 1'b0} >> amtLow;
  assign asrExt = $signed({rdVal, 1'b0}) >>> amtLow;
  assign rorExt = {rdVal, rdVal} >> amtLow;

  always_comb begin
    shRes    = rdVal;
    shC      = curC;
    shCValid = (amt != 8'd0);
    if (amt != 8'd0) begin
      unique case (strobes.shKind)
        SH_LEFT: begin
          if (amt < AMT_FULL) begin shRes = lslExt[W-1:0]; shC = lslExt[W]; end
          else begin shRes = '0; shC = (amt == AMT_FULL) ? rdVal[0] : 1'b0; end
        end
        SH_RIGHT: begin
          if (amt < AMT_FULL) begin shRes = lsrExt[W:1]; shC = lsrExt[0]; end
          else begin shRes = '0; shC = (amt == AMT_FULL) ? rdVal[W-1] : 1'b0; end
        end
        SH_ARITH: begin
          if (amt < AMT_FULL) begin shRes = asrExt[W:1]; shC = asrExt[0]; end
          else begin shRes = {W{rdVal[W-1]}}; shC = rdVal[W-1]; end
        end
        default: begin
          shRes = rorExt[W-1:0];
          shC   = rorExt[W-1];
        end
      endcase
    end
  end

  // Result and flag selection
  always_comb begin
    nextRes = lgRes;
    nextC   = curC;
    nextV   = nzcv[0];
    if (strobes.isArith) begin
      nextRes = addSum;
      nextC   = addCout;
      nextV   = addOvf;
    end else if (strobes.isShift) begin
      nextRes = shRes;
      if (shCValid) nextC = shC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wrEn     <= 1'b0;
      wrIdx    <= '0;
      result   <= '0;
      nzcv     <= '0;
    end else begin
      outValid <= inValid;
      wrEn     <= inValid && strobes.wrBack;
      if (inValid) begin
        wrIdx  <= dstIdx;
        result <= nextRes;
        nzcv   <= {nextRes[W-1], (nextRes == '0), nextC, nextV};
      end
    end
  end
endmodule

// File: rtl/rr_alu_unit.sv
module rr_alu_unit
  import rr_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [W-1:0]       rdVal,
  input  logic [W-1:0]       rsVal,
  output logic               outValid,
  output logic               wrEn,
  output logic [2:0]         wrIdx,
  output logic [W-1:0]       result,
  output logic [3:0]         nzcv
);
  alu_ctrl_t strobes;

  rr_alu_ctrl uCtrl (
    .opField (instr[9:6]),
    .strobes (strobes)
  );

  rr_alu_dpath #(.W(W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .dstIdx   (instr[2:0]),
    .rdVal    (rdVal),
    .rsVal    (rsVal),
    .outValid (outValid),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .result   (result),
    .nzcv     (nzcv)
  );
endmodule

// File: rtl/rr_alu_checker.sv
module rr_alu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [15:0]  instr,
  input logic [W-1:0] rdVal,
  input logic [W-1:0] rsVal,
  input logic         outValid,
  input logic         wrEn,
  input logic [2:0]   wrIdx,
  input logic [W-1:0] result,
  input logic [3:0]   nzcv
);
  logic isCompare, isShiftOp, isLogicOp;
  assign isCompare = (instr[9:6] == 4'b1000) || (instr[9:6] == 4'b1010) ||
                     (instr[9:6] == 4'b1011);
  assign isShiftOp = (instr[9:6] == 4'b0010) || (instr[9:6] == 4'b0011) ||
                     (instr[9:6] == 4'b0100) || (instr[9:6] == 4'b0111);
  assign isLogicOp = (instr[9:6] == 4'b0000) || (instr[9:6] == 4'b0001) ||
                     (instr[9:6] == 4'b1100) || (instr[9:6] == 4'b1101) ||
                     (instr[9:6] == 4'b1110) || (instr[9:6] == 4'b1111) ||
                     (instr[9:6] == 4'b1000);

  a_r3_no_write_compare: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isCompare |=> outValid && !wrEn);

  a_r1_write_dest: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !isCompare |=> outValid && wrEn && (wrIdx == $past(instr[2:0])));

  a_r5_nz_track: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (nzcv[3] == result[W-1]) && (nzcv[2] == (result == '0)));

  a_r7_zero_amount: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isShiftOp && (rsVal[7:0] == 8'd0) |=>
      (result == $past(rdVal)) && (nzcv[1] == $past(nzcv[1])));

  a_r9_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isLogicOp |=> nzcv[1:0] == $past(nzcv[1:0]));

  a_r9_shift_keeps_v: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isShiftOp |=> nzcv[0] == $past(nzcv[0]));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && !wrEn && $stable(nzcv));
endmodule

bind rr_alu_unit rr_alu_checker #(.W(W)) uChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .rdVal(rdVal),
  .rsVal(rsVal), .outValid(outValid), .wrEn(wrEn), .wrIdx(wrIdx),
  .result(result), .nzcv(nzcv)
);

// File: tb/rr_alu_unit_test.sv
module rr_alu_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] rdVal = '0;
  logic [31:0] rsVal = '0;
  logic        outValid, wrEn;
  logic [2:0]  wrIdx;
  logic [31:0] result;
  logic [3:0]  nzcv;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rr_alu_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr), .rdVal(rdVal),
    .rsVal(rsVal), .outValid(outValid), .wrEn(wrEn), .wrIdx(wrIdx),
    .result(result), .nzcv(nzcv)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [2:0] src, input logic [2:0] dst,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid = 1'b1;
    instr   = {6'b010000, op, src, dst};
    rdVal   = a;
    rsVal   = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runCase(input string tag, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] expRes,
                         input logic expWr, input logic [3:0] expFlags);
    issue(op, 3'd1, 3'd2, a, b);
    check({tag, " result"}, result, expRes);
    check({tag, " wrEn"}, {31'b0, wrEn}, {31'b0, expWr});
    check({tag, " nzcv"}, {28'b0, nzcv}, {28'b0, expFlags});
  endtask

  task automatic testReset();
    check("R11 outValid", {31'b0, outValid}, 32'd0);
    check("R11 wrEn", {31'b0, wrEn}, 32'd0);
    check("R11 nzcv", {28'b0, nzcv}, 32'd0);
  endtask

  task automatic testDecode();
    issue(4'b0000, 3'd5, 3'd3, 32'hF0F0_1234, 32'h0FF0_FFFF);
    check("R1 outValid", {31'b0, outValid}, 32'd1);
    check("R1 wrIdx", {29'b0, wrIdx}, 32'd3);
    check("R2 AND result", result, 32'h00F0_1234);
    check("R1 wrEn", {31'b0, wrEn}, 32'd1);
    check("R5 nzcv after AND", {28'b0, nzcv}, 32'd0);
  endtask

  task automatic testLogic();
    runCase("R2 XOR", 4'b0001, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F, 1'b1, 4'b1000);
    runCase("R5 ORR zero", 4'b1100, 32'h0, 32'h0, 32'h0, 1'b1, 4'b0100);
    runCase("R2 BIC", 4'b1110, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 1'b1, 4'b1000);
    runCase("R2 MVN", 4'b1111, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'b0100);
    runCase("R2 MUL", 4'b1101, 32'h0001_0000, 32'h0001_0003, 32'h0003_0000, 1'b1, 4'b0000);
  endtask

  task automatic testArith();
    runCase("R3 CMP sets C V", 4'b1010, 32'h8000_0000, 32'h1, 32'h7FFF_FFFF, 1'b0, 4'b0011);
    runCase("R9 AND keeps CV", 4'b0000, 32'h1, 32'h1, 32'h1, 1'b1, 4'b0011);
    runCase("R4 ADC carry in", 4'b0101, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b1, 4'b0110);
    runCase("R4 ADC overflow", 4'b0101, 32'h7FFF_FFFF, 32'h0, 32'h8000_0000, 1'b1, 4'b1001);
    runCase("R4 SBC borrow", 4'b0110, 32'h5, 32'h3, 32'h1, 1'b1, 4'b0010);
    runCase("R4 NEG one", 4'b1001, 32'hDEAD_BEEF, 32'h1, 32'hFFFF_FFFF, 1'b1, 4'b1000);
    runCase("R4 NEG min", 4'b1001, 32'h0, 32'h8000_0000, 32'h8000_0000, 1'b1, 4'b1001);
    runCase("R4 NEG zero", 4'b1001, 32'h5, 32'h0, 32'h0, 1'b1, 4'b0110);
    runCase("R3 CMN", 4'b1011, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1'b0, 4'b1001);
    runCase("R3 TST", 4'b1000, 32'h0000_00F0, 32'h0000_000F, 32'h0, 1'b0, 4'b0101);
  endtask

  task automatic testShiftSmall();
    runCase("R6 LSL 1", 4'b0010, 32'h8000_0001, 32'h1, 32'h2, 1'b1, 4'b0011);
    runCase("R6 LSR 1", 4'b0011, 32'h3, 32'h1, 32'h1, 1'b1, 4'b0011);
    runCase("R6 ASR 4", 4'b0100, 32'h8000_0000, 32'hFFFF_FF04, 32'hF800_0000, 1'b1, 4'b1001);
    runCase("R6 ROR 1", 4'b0111, 32'h1, 32'h1, 32'h8000_0000, 1'b1, 4'b1011);
    runCase("R7 zero amount", 4'b0010, 32'h1234_5678, 32'hFFFF_FF00, 32'h1234_5678, 1'b1, 4'b0011);
  endtask

  task automatic testShiftLarge();
    runCase("R8 LSL 32", 4'b0010, 32'h1, 32'd32, 32'h0, 1'b1, 4'b0111);
    runCase("R8 LSR 32", 4'b0011, 32'h7FFF_FFFF, 32'd32, 32'h0, 1'b1, 4'b0101);
    runCase("R8 LSL 33", 4'b0010, 32'hFFFF_FFFF, 32'd33, 32'h0, 1'b1, 4'b0101);
    runCase("R8 ASR 40", 4'b0100, 32'h8000_0000, 32'd40, 32'hFFFF_FFFF, 1'b1, 4'b1011);
    runCase("R8 ASR 200", 4'b0100, 32'h4000_0000, 32'd200, 32'h0, 1'b1, 4'b0101);
    runCase("R8 ROR 32", 4'b0111, 32'h8000_0001, 32'd32, 32'h8000_0001, 1'b1, 4'b1011);
    runCase("R8 ROR 36", 4'b0111, 32'h0000_00F0, 32'd36, 32'h0000_000F, 1'b1, 4'b0001);
  endtask

  task automatic testIdle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      instr = {6'b010000, 4'(i + 9), 3'd0, 3'd0};
      rdVal = 32'h0;
      rsVal = 32'hFFFF_FFFF;
      @(negedge clk);
      check("R10 outValid idle", {31'b0, outValid}, 32'd0);
      check("R10 wrEn idle", {31'b0, wrEn}, 32'd0);
      check("R10 nzcv hold", {28'b0, nzcv}, 32'b0001);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testDecode();
    testLogic();
    testArith();
    testShiftSmall();
    testShiftLarge();
    testIdle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule